// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N synthesizer, written as one clocked digital design. Every rising edge of `clk_in` stands for one cycle of the oscillator input. The chain has three counters:

- a prescaler that takes either 10 or 11 input cycles per step;
- a swallow counter that holds the prescaler at 11 for the first A steps of each output period;
- a main counter that ends the output period after M+1 prescaler steps.

With bypass low, one output period lasts 10·(M+1)+A input cycles. With bypass high, the prescaler and the swallow counter are idle and the chain divides by M+1.

The programmed values `m_val`, `a_val` and `bypass` are captured at the start of each output period. The block captures them again whenever reset is asserted. A change part-way through a period therefore waits for the next period boundary. If A is larger than M+1, the block raises `param_err` and uses M+1 in place of A.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst_n` is low on a rising edge, every counter is reloaded from the current inputs and `fp_out` stays low. The first rising edge with `rst_n` high is cycle 0 of a fresh period.
- R2: With bypass low and A ≤ M+1, each output period lasts exactly 10·(M+1)+A input cycles. With M=8 and A stepping from 0 to 9, this gives the contiguous ratios 90 to 99.
- R3: With bypass low, `mod11_sel` is high for the first 11·A input cycles of each period. It is low for the remaining 10·(M+1−A) cycles, and once low it does not rise again before the period ends.
- R4: With bypass high, each output period lasts exactly M+1 input cycles and `mod11_sel` stays low.
- R5: `fp_out` is high for exactly one input cycle per period, in the last cycle of that period. This requires M ≥ 1.
- R6: Changes to `m_val`, `a_val` or `bypass` in the middle of a period do not alter that period. They take effect from the first cycle of the next period.
- R7: `param_err` is high exactly when `a_val` > `m_val`+1. It follows the current inputs with no delay.
- R8: When A > M+1, the divider behaves as if A = M+1. The period is then 11·(M+1) input cycles and `mod11_sel` is high throughout it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Oscillator-rate input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_val | input | 9 | Main counter setting M (legal range 1..511) |
| a_val | input | 4 | Swallow count A (0..15) |
| bypass | input | 1 | High: skip the prescaler and divide by M+1 |
| fp_out | output | 1 | One-cycle pulse in the last cycle of each period |
| mod11_sel | output | 1 | High while the prescaler takes 11 cycles per step |
| param_err | output | 1 | High when `a_val` exceeds `m_val`+1 |

## Verification
The hardest case to reach is a change of inputs part-way through a period, because the old settings must stay in force until the boundary. This is also where the bypass switch, the clamped swallow count and the fresh start after reset meet the reload logic. The stimulus changes M, A and bypass at odd offsets inside running periods, including offsets that fall inside the swallow phase. It also asserts reset in the middle of a period. The bench reference model captures the settings only at the boundaries it computes itself. Any early reload or any missed reload therefore shows up as a pulse or a modulus flag in the wrong cycle.

// File: rtl/pswallow_pkg.sv
// Package: widths and moduli shared by the divider chain and its checker.
package pswallow_pkg;
    localparam int unsigned PSW_M_W     = 9;   // main counter setting width
    localparam int unsigned PSW_A_W     = 4;   // swallow count width
    localparam int unsigned PSW_LOW_MOD = 10;  // low prescaler modulus; high is +1
endpackage

// File: rtl/psw_prescaler.sv
// psw_prescaler: counts input cycles inside one prescaler step.
// Each step lasts LOW_MOD+1 cycles when long_next is set, LOW_MOD cycles
// otherwise, and one cycle in bypass.
// Assumes: the caller supplies the length of the following step through
// byp_next and long_next, valid whenever tc or reset is present.
module psw_prescaler #(
    parameter int unsigned LOW_MOD = pswallow_pkg::PSW_LOW_MOD,
    localparam int unsigned PW     = $clog2(LOW_MOD + 1)
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          byp_next,
    input  logic          long_next,
    output logic          tc,
    output logic [PW-1:0] cnt
);
    logic [PW-1:0] cnt_q;
    logic [PW-1:0] reload;

    // Start value of the next step: bypass 0, long step LOW_MOD, short LOW_MOD-1.
    always_comb begin
        if (byp_next)
            reload = '0;
        else if (long_next)
            reload = PW'(LOW_MOD);
        else
            reload = PW'(LOW_MOD - 1);
    end

    // Count down, restarting at the terminal count or while reset is held.
    always_ff @(posedge clk_in) begin
        if (!rst_n || tc)
            cnt_q <= reload;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tc  = (cnt_q == '0);
    assign cnt = cnt_q;
endmodule

// File: rtl/psw_main_counter.sv
// psw_main_counter: counts prescaler steps. It reports the final step of the
// output period, which is the (M+1)-th step.
// Assumes: restart coincides with a prescaler terminal count or reset.
module psw_main_counter #(
    parameter int unsigned M_W = pswallow_pkg::PSW_M_W
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           step,
    input  logic [M_W-1:0] m_in,
    output logic           last,
    output logic [M_W-1:0] cnt
);
    logic [M_W-1:0] cnt_q;

    // Load M at a period start, otherwise decrement once per prescaler step.
    always_ff @(posedge clk_in) begin
        if (!rst_n || restart)
            cnt_q <= m_in;
        else if (step)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
    assign cnt  = cnt_q;
endmodule

// File: rtl/psw_swallow_counter.sv
// psw_swallow_counter: holds how many long prescaler steps remain in the
// current period. It also clamps the programmed count to M+1 and flags
// settings that are out of range.
// Assumes: restart marks the last cycle of a period; in bypass it loads 0.
module psw_swallow_counter #(
    parameter int unsigned M_W = pswallow_pkg::PSW_M_W,
    parameter int unsigned A_W = pswallow_pkg::PSW_A_W,
    localparam int unsigned CW = (M_W > A_W ? M_W : A_W) + 1
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           step,
    input  logic           bypass_in,
    input  logic [M_W-1:0] m_in,
    input  logic [A_W-1:0] a_in,
    output logic           remain_nz,
    output logic           next_nz,
    output logic           param_err,
    output logic [A_W-1:0] cnt
);
    logic [A_W-1:0] cnt_q;
    logic [A_W-1:0] a_eff;
    logic [A_W-1:0] cnt_d;
    logic [CW-1:0]  m_plus1;

    // Clamp the swallow count to M+1 and flag the range violation.
    always_comb begin
        m_plus1   = CW'(m_in) + CW'(1);
        param_err = (CW'(a_in) > m_plus1);
        a_eff     = param_err ? A_W'(m_plus1) : a_in;
    end

    // Next remaining count: reload at a period start, step down while nonzero.
    always_comb begin
        if (!rst_n || restart)
            cnt_d = bypass_in ? '0 : a_eff;
        else if (step && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    // Remaining long-step register.
    always_ff @(posedge clk_in) begin
        cnt_q <= cnt_d;
    end

    assign remain_nz = (cnt_q != '0);
    assign next_nz   = (cnt_d != '0);
    assign cnt       = cnt_q;
endmodule

// File: rtl/pswallow_divider.sv
// pswallow_divider: top of the dual-modulus feedback divider. Ratio is
// LOW_MOD*(M+1)+A, or M+1 with bypass high.
// Assumes: clk_in is the oscillator-rate clock; M >= 1 for a pulse one cycle
// wide; settings are captured only at period boundaries and during reset.
module pswallow_divider #(
    parameter int unsigned M_W     = pswallow_pkg::PSW_M_W,
    parameter int unsigned A_W     = pswallow_pkg::PSW_A_W,
    parameter int unsigned LOW_MOD = pswallow_pkg::PSW_LOW_MOD
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [M_W-1:0] m_val,
    input  logic [A_W-1:0] a_val,
    input  logic           bypass,
    output logic           fp_out,
    output logic           mod11_sel,
    output logic           param_err
);
    localparam int unsigned PW = $clog2(LOW_MOD + 1);

    logic           byp_q;
    logic           byp_next;
    logic           pre_tc;
    logic           main_last;
    logic           period_end;
    logic           swal_nz;
    logic           swal_next_nz;
    logic [PW-1:0]  pre_cnt;
    logic [M_W-1:0] main_cnt;
    logic [A_W-1:0] swal_cnt;

    assign period_end = pre_tc && main_last;
    assign byp_next   = (!rst_n || period_end) ? bypass : byp_q;

    // Bypass setting in force for the current period.
    always_ff @(posedge clk_in) begin
        if (!rst_n || period_end)
            byp_q <= bypass;
    end

    psw_prescaler #(.LOW_MOD(LOW_MOD)) u_pre (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .byp_next  (byp_next),
        .long_next (swal_next_nz),
        .tc        (pre_tc),
        .cnt       (pre_cnt)
    );

    psw_main_counter #(.M_W(M_W)) u_main (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .restart (period_end),
        .step    (pre_tc),
        .m_in    (m_val),
        .last    (main_last),
        .cnt     (main_cnt)
    );

    psw_swallow_counter #(.M_W(M_W), .A_W(A_W)) u_swal (
        .clk_in    (clk_in),
        .rst_n     (rst_n),
        .restart   (period_end),
        .step      (pre_tc),
        .bypass_in (bypass),
        .m_in      (m_val),
        .a_in      (a_val),
        .remain_nz (swal_nz),
        .next_nz   (swal_next_nz),
        .param_err (param_err),
        .cnt       (swal_cnt)
    );

    assign fp_out    = period_end;
    assign mod11_sel = swal_nz && !byp_q;
endmodule

// File: rtl/psw_checker.sv
// psw_checker: temporal properties of the divider chain, bound to the top.
// Assumes: M >= 1 is applied while running.
module psw_checker #(
    parameter int unsigned M_W     = pswallow_pkg::PSW_M_W,
    parameter int unsigned A_W     = pswallow_pkg::PSW_A_W,
    parameter int unsigned LOW_MOD = pswallow_pkg::PSW_LOW_MOD,
    localparam int unsigned PW     = $clog2(LOW_MOD + 1)
) (
    input logic           clk_in,
    input logic           rst_n,
    input logic           fp_out,
    input logic           mod11_sel,
    input logic           pre_tc,
    input logic [PW-1:0]  pre_cnt,
    input logic [M_W-1:0] main_cnt,
    input logic [A_W-1:0] swal_cnt
);
    // R5: the output pulse never lasts two cycles.
    p_fp_single_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
        fp_out |=> !fp_out);

    // R3: once the long-step flag drops it stays low until the period ends.
    p_mod11_no_rise_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!mod11_sel && !fp_out) |=> !mod11_sel);

    // R2: the main counter only moves on a prescaler terminal count.
    p_main_hold_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!pre_tc && !fp_out) |=> $stable(main_cnt));

    // R3: the swallow count never grows inside a period.
    p_swal_down_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
        !fp_out |=> (swal_cnt <= $past(swal_cnt)));

    // R2: the prescaler count stays within the long modulus.
    p_pre_range_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
        pre_cnt <= PW'(LOW_MOD));

    // R1: a reset edge leaves the output pulse low.
    p_reset_quiet_r1: assert property (@(posedge clk_in)
        !rst_n |=> !fp_out);
endmodule

bind pswallow_divider psw_checker #(.M_W(M_W), .A_W(A_W), .LOW_MOD(LOW_MOD)) chk_i (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .fp_out    (fp_out),
    .mod11_sel (mod11_sel),
    .pre_tc    (pre_tc),
    .pre_cnt   (pre_cnt),
    .main_cnt  (main_cnt),
    .swal_cnt  (swal_cnt)
);

// File: tb/pswallow_divider_tb_top.sv
module pswallow_divider_tb_top;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [8:0] m_val  = 9'd8;
    logic [3:0] a_val  = 4'd0;
    logic       bypass = 1'b0;
    logic       fp_out, mod11_sel, param_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  live   = 1'b0;
    string tag  = "R1";

    // behavioural reference model state
    int pos = 0, len = 90, aeff = 0;
    bit lbyp = 1'b0;

    always #10 clk_in = ~clk_in;

    pswallow_divider dut_i (
        .clk_in(clk_in), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
        .bypass(bypass), .fp_out(fp_out), .mod11_sel(mod11_sel),
        .param_err(param_err)
    );

    task automatic capture();
        int m = int'(m_val);
        int a = int'(a_val);
        lbyp = bypass;
        aeff = (a > m + 1) ? m + 1 : a;
        len  = lbyp ? m + 1 : 10 * (m + 1) + aeff;
    endtask

    // Reference model: advances one input cycle per rising edge.
    always @(posedge clk_in) begin
        if (!rst_n) begin
            pos = 0;
            capture();
        end else if (pos == len - 1) begin
            pos = 0;
            capture();
        end else begin
            pos = pos + 1;
        end
    end

    task automatic chk1(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at pos %0d", tag, what, act, exp, pos);
        end
    endtask

    // One cycle: wait for the falling edge, then compare every output.
    task automatic tick();
        @(negedge clk_in);
        if (live) begin
            chk1("fp_out", fp_out, (pos == len - 1));
            chk1("mod11_sel", mod11_sel, !lbyp && (pos < 11 * aeff));
            chk1("param_err", param_err, (int'(a_val) > int'(m_val) + 1));
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic setv(input int m, input int a, input bit b);
        m_val = 9'(m); a_val = 4'(a); bypass = b;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state, then a fresh first period
        run(3);
        live = 1'b1;
        run(2);
        rst_n = 1'b1;
        run(200);
        // R2: contiguous range M=8, A=9 gives 99
        tag = "R2"; setv(8, 9, 0); run(300);
        // R2: minimum M, A at the M+1 limit (22)
        setv(1, 2, 0); run(120);
        // R3: long phase covering several steps
        tag = "R3"; setv(6, 5, 0); run(260);
        // R4: bypass ratios M+1
        tag = "R4"; setv(5, 3, 1); run(40);
        setv(1, 0, 1); run(20);
        setv(511, 0, 1); run(1100);
        // R8: clamp A=15 to M+1=4, period 44
        tag = "R8"; setv(3, 15, 0); run(140);
        // R7: error flag follows the inputs
        tag = "R7"; setv(13, 15, 0); tick(); setv(14, 15, 0); tick();
        setv(2, 4, 0); tick(); setv(2, 3, 0); run(80);
        // R6: changes at odd offsets inside periods, bypass toggling mid-period
        tag = "R6";
        for (int k = 0; k < 24; k++) begin
            setv(1 + (k * 7) % 12, (k * 5) % 16, (k % 5) == 3);
            run(13 + (k * 11) % 41);
        end
        run(200);
        // R1: reset asserted mid-period, then a fresh start
        tag = "R1"; setv(4, 2, 0); run(17);
        rst_n = 1'b0; run(3); setv(7, 6, 0); tick();
        rst_n = 1'b1; run(250);
        // R5: steady running, single pulse per period checked every cycle
        tag = "R5"; setv(2, 1, 0); run(120);
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk_in);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_up();
        end
    end
endmodule